// File: doc/BRIEF.md
# SPI Snapshot Register Slave

This block is a serial slave with a 64-bit shift register at its centre. When the master pulls chip select low, the block copies the current values of its readable registers into the shift register in one step. During the transfer, each bit clock sends one bit out and takes one bit in, most significant bit first. When chip select goes high again, the last sixteen bits received can become the block's two writable control registers.

The framing counts back from the end of the transfer. The final byte received is the control byte, and the byte before it is the block-control byte. The master pads the front of a longer or shorter transfer so that these two bytes arrive last. Both registers are loaded together, and only when the top bit of the final byte is 1.

The slave uses SPI mode 0 and runs in the system clock domain. Each serial input passes through a two-flop synchroniser before its edges are detected, so the system clock must run at least four times faster than the bit clock. A control FSM has three states:
- `ST_IDLE`: waiting, serial output low.
- `ST_SHIFT`: transfer in progress.
- `ST_COMMIT`: one cycle that decides whether to load the registers.

The FSM has four transitions:
- IDLE→SHIFT on a chip-select fall, which also loads the snapshot.
- SHIFT→SHIFT while chip select stays low.
- SHIFT→COMMIT on a chip-select rise.
- COMMIT→IDLE unconditionally.

Top module: `spi_snap_slave`

## Requirements
- R1: After reset, both writable registers are 0x00, the serial output is 0 and the write strobe is 0.
- R2: While chip select is high, the serial output is 0.
- R3: The 64 bits read out, first bit first, are fixed as follows:
  - byte 0: the current control register;
  - byte 1: quality;
  - byte 2: position;
  - bytes 3 and 4: the data word, high byte first;
  - byte 5: the current block-control register;
  - 14 flag bits, highest first;
  - the two test bits, bit 1 before bit 0.
- R4: The serial output changes only after a falling bit-clock edge, so it is valid before each rising edge.
- R5: The serial input is sampled on rising bit-clock edges. At the end of a commit, the control register holds the last byte received and the block-control register holds the byte before it, each with its first received bit as its MSB.
- R6: A commit happens only when bit 7 of the last byte received is 1. If that bit is 0, both registers keep their values.
- R7: A transfer of fewer than 16 bits commits nothing, whatever bit it ends with.
- R8: Each commit produces a write strobe that is high for exactly one system clock cycle. The registers change only in the cycle the strobe is high.
- R9: A transfer longer than 64 bits, or shorter than 64 bits but at least 16, still commits its last 16 bits.
- R10: The snapshot is taken when chip select falls. Input ports that change later in the transfer do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial bit clock from master |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| qual_in | input | 8 | Quality byte source |
| pos_in | input | 8 | Position byte source |
| data_in | input | 16 | Data word source |
| flag_in | input | SR_W-50 | Status flag bits |
| test_in | input | 2 | Test bits, read out last |
| ctrl_reg | output | 8 | Writable control register |
| blk_reg | output | 8 | Writable block-control register |
| wr_strobe | output | 1 | One-cycle commit pulse |

## Verification
A wrong bit counter or a bad shift direction shows up on the serial output within the same transfer. A wrong received tail shows up in the register values within a few system cycles after chip select rises. A faulty commit gate shows up either as a register that changes when the final byte has bit 7 clear, or as a strobe after a short transfer. In the next transfer, the first byte read back repeats the control register, so a corrupted commit is visible on the serial line as well. A snapshot that is not frozen shows up as readout bits that follow inputs changed in the middle of a transfer.

// File: rtl/spi_snap_pkg.sv
package spi_snap_pkg;
    localparam int BYTE_W  = 8;
    localparam int TAIL_W  = 2 * BYTE_W;
    localparam int SYNC_N  = 3;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } snap_state_t;
endpackage

// File: rtl/spi_snap_sync.sv
module spi_snap_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] stage1;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[g] <= RST_VAL[g];
                q[g]      <= RST_VAL[g];
                q_prev[g] <= RST_VAL[g];
            end else begin
                stage1[g] <= d_async[g];
                q[g]      <= stage1[g];
                q_prev[g] <= q[g];
            end
        end
    end
endmodule

// File: rtl/spi_snap_shifter.sv
module spi_snap_shifter
    import spi_snap_pkg::*;
#(
    parameter int SR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SR_W-1:0]   snap,
    input  logic              en,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi,
    output logic              out_bit,
    output logic [TAIL_W-1:0] tail,
    output logic              tail_ok
);
    localparam int CNT_W = $clog2(TAIL_W + 1);

    logic [SR_W-1:0]  sr;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            cnt     <= '0;
            out_bit <= 1'b0;
        end else if (load) begin
            sr      <= snap;
            cnt     <= '0;
            out_bit <= snap[SR_W-1];
        end else if (en) begin
            if (sck_rise) begin
                sr <= {sr[SR_W-2:0], mosi};
                if (cnt != CNT_W'(TAIL_W))
                    cnt <= cnt + 1'b1;
            end
            if (sck_fall)
                out_bit <= sr[SR_W-1];
        end
    end

    assign tail    = sr[TAIL_W-1:0];
    assign tail_ok = (cnt == CNT_W'(TAIL_W));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(TAIL_W));
endmodule

// File: rtl/spi_snap_fsm.sv
module spi_snap_fsm
    import spi_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic [TAIL_W-1:0] tail,
    input  logic              tail_ok,
    output logic              load,
    output logic              shifting,
    output logic [BYTE_W-1:0] ctrl_reg,
    output logic [BYTE_W-1:0] blk_reg,
    output logic              wr_strobe
);
    snap_state_t state, state_nx;
    logic        do_commit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign load      = (state == ST_IDLE) && cs_fall;
    assign shifting  = (state == ST_SHIFT);
    assign do_commit = (state == ST_COMMIT) && tail_ok && tail[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_reg  <= '0;
            blk_reg   <= '0;
            wr_strobe <= 1'b0;
        end else begin
            wr_strobe <= do_commit;
            if (do_commit) begin
                ctrl_reg <= tail[BYTE_W-1:0];
                blk_reg  <= tail[TAIL_W-1:BYTE_W];
            end
        end
    end

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);
    assert_regs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |-> ($stable(ctrl_reg) && $stable(blk_reg)));
    assert_commit_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> ctrl_reg[BYTE_W-1]);
    assert_commit_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(tail_ok));
endmodule

// File: rtl/spi_snap_slave.sv
module spi_snap_slave
    import spi_snap_pkg::*;
#(
    parameter int SR_W   = 64,
    localparam int FLAG_W = SR_W - 6 * BYTE_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [7:0]        qual_in,
    input  logic [7:0]        pos_in,
    input  logic [15:0]       data_in,
    input  logic [FLAG_W-1:0] flag_in,
    input  logic [1:0]        test_in,
    output logic [7:0]        ctrl_reg,
    output logic [7:0]        blk_reg,
    output logic              wr_strobe
);
    logic [SYNC_N-1:0] s_now, s_prev;
    logic              cs_fall, cs_rise, sck_rise, sck_fall;
    logic              load, shifting, out_bit, tail_ok;
    logic [TAIL_W-1:0] tail;
    logic [SR_W-1:0]   snap;

    spi_snap_sync #(.W(SYNC_N), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({spi_csn, spi_sck, spi_mosi}),
        .q(s_now), .q_prev(s_prev)
    );

    assign cs_fall  =  s_prev[2] && !s_now[2];
    assign cs_rise  = !s_prev[2] &&  s_now[2];
    assign sck_rise = !s_prev[1] &&  s_now[1];
    assign sck_fall =  s_prev[1] && !s_now[1];

    assign snap = {ctrl_reg, qual_in, pos_in, data_in, blk_reg, flag_in, test_in};

    spi_snap_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .tail(tail), .tail_ok(tail_ok),
        .load(load), .shifting(shifting),
        .ctrl_reg(ctrl_reg), .blk_reg(blk_reg), .wr_strobe(wr_strobe)
    );

    spi_snap_shifter #(.SR_W(SR_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(load), .snap(snap), .en(shifting),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi(s_now[0]),
        .out_bit(out_bit), .tail(tail), .tail_ok(tail_ok)
    );

    assign spi_miso = shifting && out_bit;

    assert_miso_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_now[2] && s_prev[2]) |-> !spi_miso);
    assert_miso_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && !$past(sck_fall) && !$past(load)) |-> $stable(spi_miso));
endmodule

// File: tb/spi_snap_slave_bench.sv
module spi_snap_slave_bench;
    localparam int SR_W = 64;
    localparam int FW   = SR_W - 50;
    localparam int PH   = 6;

    logic clk = 0, rst_n = 0, sck = 0, csn = 1, mosi = 0;
    logic miso, wr_strobe;
    logic [7:0] qual, pos, ctrl, blk;
    logic [15:0] dat;
    logic [FW-1:0] flg;
    logic [1:0] tst;

    int checks = 0, fails = 0, strobes = 0;
    logic [7:0] m_ctrl = 0, m_blk = 0;
    int m_strobes = 0;

    always #10 clk = ~clk;

    spi_snap_slave u_spi_snap_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn),
        .spi_mosi(mosi), .spi_miso(miso), .qual_in(qual), .pos_in(pos),
        .data_in(dat), .flag_in(flg), .test_in(tst), .ctrl_reg(ctrl),
        .blk_reg(blk), .wr_strobe(wr_strobe)
    );

    always @(posedge clk) if (rst_n && wr_strobe) strobes++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_snap(input logic [7:0] c, input logic [7:0] b);
        return {c, qual, pos, dat, b, flg, tst};
    endfunction

    function automatic logic expect_commit(input int n, input logic [255:0] tx);
        return (n >= 16) && tx[7];
    endfunction

    task automatic rand_inputs();
        qual = 8'($urandom); pos = 8'($urandom); dat = 16'($urandom);
        flg = FW'($urandom); tst = 2'($urandom);
    endtask

    task automatic xfer(input int n, input logic [255:0] tx, input bit scramble, input string tag);
        logic [63:0] snap_e, rx;
        int lim;
        rx = '0;
        @(negedge clk);
        snap_e = exp_snap(m_ctrl, m_blk);
        csn = 0;
        repeat (PH) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            mosi = tx[n-1-i];
            if (scramble && i == 3) rand_inputs();
            repeat (PH) @(negedge clk);
            if (i < 64) rx[63-i] = miso;
            sck = 1;
            repeat (PH) @(negedge clk);
            sck = 0;
        end
        repeat (PH) @(negedge clk);
        csn = 1;
        repeat (10) @(negedge clk);
        lim = (n < 64) ? n : 64;
        // R3 R4 R10: readout equals snapshot frozen at chip-select fall
        chk({"R3 readout ", tag}, rx >> (64 - lim), snap_e >> (64 - lim));
        if (expect_commit(n, tx)) begin
            m_ctrl = tx[7:0]; m_blk = tx[15:8]; m_strobes++;
        end
        chk({"R5 R6 R9 ctrl ", tag}, 64'(ctrl), 64'(m_ctrl));
        chk({"R5 R6 R9 blk ", tag}, 64'(blk), 64'(m_blk));
        chk({"R8 strobe count ", tag}, 64'(strobes), 64'(m_strobes));
        chk({"R2 idle miso ", tag}, 64'(miso), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rand_inputs();
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 ctrl", 64'(ctrl), 0);
        chk("R1 blk", 64'(blk), 0);
        chk("R1 miso", 64'(miso), 0);
        chk("R1 strobe", 64'(wr_strobe), 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        // R2 idle with nonzero snapshot sources
        qual = 8'hFF; dat = 16'hFFFF;
        chk("R2 idle", 64'(miso), 0);
        xfer(64, 256'h0123_4567_89AB_A5C3, 0, "R5 write");
        xfer(64, 256'hFFFF_FFFF_FFFF_5A7F, 0, "R6 gated");
        xfer(15, 256'h7FFF, 0, "R7 short");
        xfer(16, 256'hC381, 0, "R9 exact16");
        xfer(100, {156'd0, 100'hF_0F0F_0F0F_0F0F_0F0F_0F0F_3CE6}, 0, "R9 long");
        xfer(64, 256'h1111_2222_3333_4480, 1, "R10 scramble");
        for (int k = 0; k < 25; k++) begin
            int n;
            logic [255:0] tx;
            n = 8 + int'($urandom_range(0, 88));
            tx = {$urandom, $urandom, $urandom, $urandom};
            rand_inputs();
            xfer(n, tx, k[0], "random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule